// File: doc/BRIEF.md
# Data Access Fault Checker

This block sits after the lookup stage of a data-side address translator. Each cycle that a load or store is presented, it receives the virtual address, the access size in bytes as a power of two, the store flag, the current privilege mode and request qualifiers. It also receives the lookup hit and the matching page entry: frame number, per-mode read and write enables, and the fault-on-read and fault-on-write bits. From these it decides whether the access passes or which single fault class it raises.

One cycle after the request, the block presents the verdict on its response port. A fault carries a class code and an exception vector. A passing access carries the physical address. On a fault that is allowed to be recorded, the block captures three registers for the handler: the faulting address, a packed status word built from the instruction's opcode, its Ra register number and six cause bits, and a formatted page-table-entry address. That last value is the page-table base ORed with the virtual page number shifted left by three.

Top module: `dfc_top`

## Requirements
- R1: After reset, rsp_valid, rsp_fault, rsp_class, rsp_vector, rsp_pa, flt_va, flt_stat and flt_form are all zero.
- R2: Alignment is checked first. When req_va AND (2^req_size − 1) is nonzero, the class is 1 (unaligned) with vector 0x0301. The cause bits hold only write (bit 0) on a store.
- R3: When bits 31:29 of the address (default parameters) are not all equal, the address is invalid. The class is 3 (page fault) with vector 0x0381, and the cause is bad-VA (bit 5) plus access-violation (bit 1), plus write (bit 0) on a store.
- R4: A valid address with bit 31 set and bit 28 clear is direct-mapped. In mode 0 (kernel) it passes with rsp_pa equal to the low PA_W address bits. In any other mode it raises class 2 (access violation), vector 0x0381, with cause access-violation plus write on a store. The lookup result is ignored on this path.
- R5: A mapped access that misses the lookup has cause miss (bit 4) plus write on a store. Its class is 5 (vector 0x0101) when req_pte_load is set and 4 (vector 0x0201) otherwise.
- R6: On a store hit whose write-enable bit for the current mode is clear, the class is 3 with cause write, access-violation and fault-on-write (bit 3) when the entry's fault-on-write bit is set. With write enabled but fault-on-write set, the class is 3 with cause write and fault-on-write only.
- R7: On a load hit whose read-enable bit for the current mode is clear, the class is 2 with cause access-violation, plus fault-on-read (bit 2) when the entry's fault-on-read bit is set. With read enabled but fault-on-read set, the class is 3 with cause fault-on-read only.
- R8: On a recorded fault, flt_va takes the request address. flt_stat takes opcode[5:0] in bits 16:11, Ra[4:0] in bits 10:6 and the cause bits in 5:0.
- R9: On a recorded fault, flt_form becomes ptbr OR (req_va[31:13] shifted left by 3).
- R10: When req_pte_load, req_nofault or req_misspec is set, flt_va, flt_stat and flt_form keep their values. The class and vector are still reported.
- R11: A mapped hit that passes every check sets rsp_fault to 0, rsp_class to 0 and rsp_pa to {pte_pfn, req_va[12:0]}.
- R12: rsp_valid is high exactly in the cycle after a cycle with req_valid high. rsp_fault and rsp_class are nonzero only with rsp_valid. rsp_pa is zero on faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access present this cycle |
| req_va | input | VA_W | Virtual address |
| req_size | input | 2 | Log2 of access size in bytes |
| req_write | input | 1 | Store when high |
| req_mode | input | MODE_W | Privilege mode, 0 is kernel |
| req_pte_load | input | 1 | Access is a page-table-entry load |
| req_nofault | input | 1 | No-fault probe |
| req_misspec | input | 1 | Access is on a misspeculated path |
| tlb_hit | input | 1 | Lookup found an entry |
| pte_pfn | input | PA_W-PAGE_SHIFT | Page frame number |
| pte_rd_en | input | MODES | Read enable per mode |
| pte_wr_en | input | MODES | Write enable per mode |
| pte_fonr | input | 1 | Entry fault-on-read |
| pte_fonw | input | 1 | Entry fault-on-write |
| inst_op | input | 6 | Faulting instruction opcode |
| inst_ra | input | 5 | Faulting instruction Ra field |
| ptbr | input | VA_W | Page-table base for formatted address |
| rsp_valid | output | 1 | Verdict present |
| rsp_fault | output | 1 | Verdict is a fault |
| rsp_class | output | 3 | Fault class code |
| rsp_vector | output | 16 | Exception vector |
| rsp_pa | output | PA_W | Physical address on pass |
| flt_va | output | VA_W | Recorded fault address |
| flt_stat | output | 17 | Recorded status word |
| flt_form | output | VA_W | Recorded formatted entry address |

## Verification
The hardest situations to reach are the second-tier permission outcomes. In those, the enable bit for the current mode is set but the fault-on-read or fault-on-write bit still forces a page fault. They must also interact with the record-suppression qualifiers, which should leave the three fault registers frozen while the class is still reported. Directed cases set each enable and fault-on bit pattern for a load and a store, repeat them with each qualifier, and then a long randomized run mixes address regions, modes, enables and qualifiers. A behavioural reference in the bench is compared with every output each clock.

// File: rtl/dfc_pkg.sv
package dfc_pkg;
  typedef enum logic [2:0] {
    FC_NONE    = 3'd0,
    FC_UNALIGN = 3'd1,
    FC_ACV     = 3'd2,
    FC_PAGE    = 3'd3,
    FC_MISS    = 3'd4,
    FC_PTEMISS = 3'd5
  } fclass_e;

  // cause bit positions inside the low status field (decoded by handler)
  localparam int CB_WR   = 0;
  localparam int CB_ACV  = 1;
  localparam int CB_FOR  = 2;
  localparam int CB_FOW  = 3;
  localparam int CB_MISS = 4;
  localparam int CB_BAD  = 5;
  localparam int CAUSE_W = 6;
  localparam int STAT_W  = 17;

  function automatic logic [15:0] vector_of(fclass_e c);
    case (c)
      FC_UNALIGN: return 16'h0301;
      FC_ACV:     return 16'h0381;
      FC_PAGE:    return 16'h0381;
      FC_MISS:    return 16'h0201;
      FC_PTEMISS: return 16'h0101;
      default:    return 16'h0000;
    endcase
  endfunction
endpackage

// File: rtl/dfc_classify.sv
module dfc_classify
  import dfc_pkg::*;
#(
  parameter int MODES  = 4,
  parameter int TOP_W  = 4,
  localparam int MODE_W = $clog2(MODES)
) (
  input  logic [2:0]         va_lo,
  input  logic [TOP_W-1:0]   va_top,
  input  logic [1:0]         size,
  input  logic               write,
  input  logic [MODE_W-1:0]  mode,
  input  logic               pte_load,
  input  logic               hit,
  input  logic [MODES-1:0]   rd_en,
  input  logic [MODES-1:0]   wr_en,
  input  logic               fonr,
  input  logic               fonw,
  output fclass_e            fclass,
  output logic [CAUSE_W-1:0] cause,
  output logic               superpage
);
  logic [2:0] amask;
  logic       misalign;
  logic       va_ok;
  logic [CAUSE_W-1:0] wbit;

  always_comb begin
    amask     = 3'((4'd1 << size) - 4'd1);
    misalign  = |(va_lo & amask);
    va_ok     = (&va_top[TOP_W-1:1]) | ~(|va_top[TOP_W-1:1]);
    superpage = va_ok & va_top[TOP_W-1] & ~va_top[0];
    wbit      = '0;
    wbit[CB_WR] = write;
  end

  // priority: alignment, validity, direct-mapped, miss, permission
  always_comb begin
    fclass = FC_NONE;
    cause  = '0;
    if (misalign) begin
      fclass = FC_UNALIGN;
      cause  = wbit;
    end else if (!va_ok) begin
      fclass = FC_PAGE;
      cause  = wbit;
      cause[CB_BAD] = 1'b1;
      cause[CB_ACV] = 1'b1;
    end else if (superpage) begin
      if (mode != '0) begin
        fclass = FC_ACV;
        cause  = wbit;
        cause[CB_ACV] = 1'b1;
      end
    end else if (!hit) begin
      fclass = pte_load ? FC_PTEMISS : FC_MISS;
      cause  = wbit;
      cause[CB_MISS] = 1'b1;
    end else if (write) begin
      if (!wr_en[mode]) begin
        fclass = FC_PAGE;
        cause[CB_WR]  = 1'b1;
        cause[CB_ACV] = 1'b1;
        cause[CB_FOW] = fonw;
      end else if (fonw) begin
        fclass = FC_PAGE;
        cause[CB_WR]  = 1'b1;
        cause[CB_FOW] = 1'b1;
      end
    end else begin
      if (!rd_en[mode]) begin
        fclass = FC_ACV;
        cause[CB_ACV] = 1'b1;
        cause[CB_FOR] = fonr;
      end else if (fonr) begin
        fclass = FC_PAGE;
        cause[CB_FOR] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dfc_format.sv
module dfc_format
  import dfc_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PA_W       = 28,
  parameter int PAGE_SHIFT = 13,
  localparam int PFN_W     = PA_W - PAGE_SHIFT
) (
  input  logic [VA_W-1:0]    va,
  input  logic [5:0]         op,
  input  logic [4:0]         ra,
  input  logic [CAUSE_W-1:0] cause,
  input  logic [VA_W-1:0]    ptbr,
  input  logic [PFN_W-1:0]   pfn,
  output logic [STAT_W-1:0]  stat,
  output logic [VA_W-1:0]    form,
  output logic [PA_W-1:0]    pa_mapped,
  output logic [PA_W-1:0]    pa_direct
);
  always_comb begin
    stat      = {op, ra, cause};
    form      = ptbr | (VA_W'(va[VA_W-1:PAGE_SHIFT]) << 3);
    pa_mapped = {pfn, va[PAGE_SHIFT-1:0]};
    pa_direct = va[PA_W-1:0];
  end
endmodule

// File: rtl/dfc_top.sv
module dfc_top
  import dfc_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int IMPL_VA_W  = 30,
  parameter int PA_W       = 28,
  parameter int PAGE_SHIFT = 13,
  parameter int MODES      = 4,
  localparam int MODE_W    = $clog2(MODES),
  localparam int PFN_W     = PA_W - PAGE_SHIFT,
  localparam int TOP_W     = VA_W - IMPL_VA_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [VA_W-1:0]    req_va,
  input  logic [1:0]         req_size,
  input  logic               req_write,
  input  logic [MODE_W-1:0]  req_mode,
  input  logic               req_pte_load,
  input  logic               req_nofault,
  input  logic               req_misspec,
  input  logic               tlb_hit,
  input  logic [PFN_W-1:0]   pte_pfn,
  input  logic [MODES-1:0]   pte_rd_en,
  input  logic [MODES-1:0]   pte_wr_en,
  input  logic               pte_fonr,
  input  logic               pte_fonw,
  input  logic [5:0]         inst_op,
  input  logic [4:0]         inst_ra,
  input  logic [VA_W-1:0]    ptbr,
  output logic               rsp_valid,
  output logic               rsp_fault,
  output logic [2:0]         rsp_class,
  output logic [15:0]        rsp_vector,
  output logic [PA_W-1:0]    rsp_pa,
  output logic [VA_W-1:0]    flt_va,
  output logic [STAT_W-1:0]  flt_stat,
  output logic [VA_W-1:0]    flt_form
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  fclass_e            cls;
  logic [CAUSE_W-1:0] cause;
  logic               sp;
  logic [STAT_W-1:0]  stat_w;
  logic [VA_W-1:0]    form_w;
  logic [PA_W-1:0]    pa_map_w, pa_dir_w;

  dfc_classify #(.MODES(MODES), .TOP_W(TOP_W)) u_cls (
    .va_lo(req_va[2:0]), .va_top(req_va[VA_W-1:IMPL_VA_W-2]),
    .size(req_size), .write(req_write), .mode(req_mode),
    .pte_load(req_pte_load), .hit(tlb_hit), .rd_en(pte_rd_en),
    .wr_en(pte_wr_en), .fonr(pte_fonr), .fonw(pte_fonw),
    .fclass(cls), .cause(cause), .superpage(sp));

  dfc_format #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT)) u_fmt (
    .va(req_va), .op(inst_op), .ra(inst_ra), .cause(cause), .ptbr(ptbr),
    .pfn(pte_pfn), .stat(stat_w), .form(form_w),
    .pa_mapped(pa_map_w), .pa_direct(pa_dir_w));

  // next-state
  logic              is_fault, rec_en;
  logic              valid_d, fault_d;
  logic [2:0]        class_d;
  logic [15:0]       vec_d;
  logic [PA_W-1:0]   pa_d;

  always_comb begin
    is_fault = req_valid && (cls != FC_NONE);
    rec_en   = is_fault && !req_pte_load && !req_nofault && !req_misspec;
    valid_d  = req_valid;
    fault_d  = is_fault;
    class_d  = is_fault ? cls : FC_NONE;
    vec_d    = is_fault ? vector_of(cls) : 16'h0000;
    if (req_valid && !is_fault) pa_d = sp ? pa_dir_w : pa_map_w;
    else                        pa_d = '0;
  end

  // response registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid  <= 1'b0;
      rsp_fault  <= 1'b0;
      rsp_class  <= '0;
      rsp_vector <= '0;
      rsp_pa     <= '0;
    end else begin
      rsp_valid  <= valid_d;
      rsp_fault  <= fault_d;
      rsp_class  <= class_d;
      rsp_vector <= vec_d;
      rsp_pa     <= pa_d;
    end
  end

  // fault record registers, enabled only on recordable faults
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      flt_va   <= '0;
      flt_stat <= '0;
      flt_form <= '0;
    end else if (rec_en) begin
      flt_va   <= req_va;
      flt_stat <= stat_w;
      flt_form <= form_w;
    end
  end
endmodule

// File: rtl/dfc_checker.sv
module dfc_checker
  import dfc_pkg::*;
#(
  parameter int VA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_pte_load,
  input logic              req_nofault,
  input logic              req_misspec,
  input logic [5:0]        inst_op,
  input logic              rsp_valid,
  input logic              rsp_fault,
  input logic [2:0]        rsp_class,
  input logic [15:0]       rsp_vector,
  input logic [VA_W-1:0]   flt_va,
  input logic [STAT_W-1:0] flt_stat
);
  assert_rsp_follows_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_no_spurious_rsp_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_fault_needs_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_valid && rsp_class != 3'd0));
  assert_unalign_vector_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fault && rsp_class == 3'd1) |-> rsp_vector == 16'h0301);
  assert_acv_vector_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fault && rsp_class == 3'd2) |-> rsp_vector == 16'h0381);
  assert_record_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_pte_load || req_nofault || req_misspec))
      |=> (flt_va == $past(flt_va) && flt_stat == $past(flt_stat)));
  assert_stat_opcode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_pte_load && !req_nofault && !req_misspec) ##1 rsp_fault
      |-> flt_stat[16:11] == $past(inst_op));
endmodule

bind dfc_top dfc_checker #(.VA_W(VA_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .req_valid(req_valid),
  .req_pte_load(req_pte_load), .req_nofault(req_nofault),
  .req_misspec(req_misspec), .inst_op(inst_op), .rsp_valid(rsp_valid),
  .rsp_fault(rsp_fault), .rsp_class(rsp_class), .rsp_vector(rsp_vector),
  .flt_va(flt_va), .flt_stat(flt_stat));

// File: tb/dfc_top_tb_top.sv
module dfc_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 0, req_write = 0, req_pte_load = 0;
  logic        req_nofault = 0, req_misspec = 0, tlb_hit = 0;
  logic [31:0] req_va = 0, ptbr = 0;
  logic [1:0]  req_size = 0, req_mode = 0;
  logic [14:0] pte_pfn = 0;
  logic [3:0]  pte_rd_en = 0, pte_wr_en = 0;
  logic        pte_fonr = 0, pte_fonw = 0;
  logic [5:0]  inst_op = 0;
  logic [4:0]  inst_ra = 0;
  logic        rsp_valid, rsp_fault;
  logic [2:0]  rsp_class;
  logic [15:0] rsp_vector;
  logic [27:0] rsp_pa;
  logic [31:0] flt_va, flt_form;
  logic [16:0] flt_stat;

  int total = 0, bad = 0;

  always #2 clk = ~clk;

  dfc_top dut_i (.*);

  // reference state
  logic        e_valid = 0, e_fault = 0;
  logic [2:0]  e_class = 0;
  logic [15:0] e_vec = 0;
  logic [27:0] e_pa = 0;
  logic [31:0] e_fva = 0, e_form = 0;
  logic [16:0] e_stat = 0;
  logic        e_supp = 0;

  function automatic logic [15:0] vec_for(int c);
    case (c) 1: return 16'h0301; 2, 3: return 16'h0381;
      4: return 16'h0201; 5: return 16'h0101; default: return 16'h0; endcase
  endfunction

  function automatic string tag_for(int c, logic wr, logic sp);
    if (c == 1) return "R2";
    if (c == 4 || c == 5) return "R5";
    if (sp) return "R4";
    if (c == 3 && wr) return "R6";
    if (c == 2 || c == 3) return "R7";
    return "R11";
  endfunction

  // behavioural reference evaluated on the inputs present at a clock edge
  task automatic model();
    int c = 0; logic [5:0] cz = 0; logic sp = 0; logic ok;
    logic [2:0] top3 = req_va[31:29];
    ok = (top3 == 3'b000) || (top3 == 3'b111);
    if ((req_va & ((32'd1 << req_size) - 1)) != 0) begin c = 1; cz = {5'b0, req_write}; end
    else if (!ok) begin c = 3; cz = 6'b100010 | {5'b0, req_write}; end
    else if (req_va[31] && !req_va[28]) begin
      sp = 1;
      if (req_mode != 0) begin c = 2; cz = 6'b000010 | {5'b0, req_write}; end
    end else if (!tlb_hit) begin c = req_pte_load ? 5 : 4; cz = 6'b010000 | {5'b0, req_write}; end
    else if (req_write) begin
      if (!pte_wr_en[req_mode]) begin c = 3; cz = 6'b000011 | (pte_fonw ? 6'b001000 : 6'b0); end
      else if (pte_fonw) begin c = 3; cz = 6'b001001; end
    end else begin
      if (!pte_rd_en[req_mode]) begin c = 2; cz = 6'b000010 | (pte_fonr ? 6'b000100 : 6'b0); end
      else if (pte_fonr) begin c = 3; cz = 6'b000100; end
    end
    if (!req_valid) c = 0;
    e_valid = req_valid;
    e_fault = (c != 0);
    e_class = c[2:0];
    e_vec   = vec_for(c);
    e_pa    = (req_valid && c == 0) ? (sp ? req_va[27:0] : {pte_pfn, req_va[12:0]}) : 28'h0;
    e_supp  = req_pte_load || req_nofault || req_misspec;
    if (c != 0 && !e_supp) begin
      e_fva  = req_va;
      e_stat = {inst_op, inst_ra, cz};
      e_form = ptbr | ({13'b0, req_va[31:13]} << 3);
    end
  endtask

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  string ltag = "R8";
  task automatic compare();
    string t = tag_for(e_class, req_write, req_va[31] && !req_va[28]);
    chk(rsp_valid == e_valid, "R12", "rsp_valid", 32'(rsp_valid), 32'(e_valid));
    chk(rsp_fault == e_fault, t, "rsp_fault", 32'(rsp_fault), 32'(e_fault));
    chk(rsp_class == e_class, t, "rsp_class", 32'(rsp_class), 32'(e_class));
    chk(rsp_vector == e_vec, t, "rsp_vector", 32'(rsp_vector), 32'(e_vec));
    chk(rsp_pa == e_pa, e_fault ? "R12" : t, "rsp_pa", 32'(rsp_pa), 32'(e_pa));
    chk(flt_va == e_fva, ltag, "flt_va", flt_va, e_fva);
    chk(flt_stat == e_stat, ltag, "flt_stat", 32'(flt_stat), 32'(e_stat));
    chk(flt_form == e_form, e_supp ? "R10" : "R9", "flt_form", flt_form, e_form);
  endtask

  // one clock: model samples at the edge, compare away from it
  logic [31:0] va_at_edge;
  task automatic cycle();
    @(posedge clk);
    va_at_edge = req_va;
    model();
    ltag = e_supp ? "R10" : "R8";
    @(negedge clk);
    compare();
  endtask

  task automatic setreq(input logic [31:0] va, input logic [1:0] sz, input logic wr,
                        input logic [1:0] md, input logic hit, input logic [3:0] rd,
                        input logic [3:0] we, input logic fr, input logic fw);
    req_valid = 1; req_va = va; req_size = sz; req_write = wr; req_mode = md;
    tlb_hit = hit; pte_rd_en = rd; pte_wr_en = we; pte_fonr = fr; pte_fonw = fw;
    pte_pfn = 15'h1234; inst_op = 6'h2C; inst_ra = 5'h11; ptbr = 32'h8000_0000;
  endtask

  task automatic quals(input logic p, input logic n, input logic m);
    req_pte_load = p; req_nofault = n; req_misspec = m;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(rsp_valid == 0 && rsp_fault == 0 && rsp_class == 0 && rsp_pa == 0,
        "R1", "rsp after reset", {rsp_valid, rsp_fault, rsp_class}, 0);
    chk(flt_va == 0 && flt_stat == 0 && flt_form == 0, "R1", "record after reset",
        flt_va | 32'(flt_stat) | flt_form, 0);
    rst_n = 1;
    repeat (3) cycle();
    // R11 pass, R2 unaligned load and store (priority over invalid VA)
    setreq(32'h0001_2348, 2'd3, 0, 2'd1, 1, 4'hF, 4'hF, 0, 0); cycle();
    setreq(32'h0001_2346, 2'd2, 1, 2'd1, 1, 4'hF, 4'hF, 0, 0); cycle();
    setreq(32'h4000_0001, 2'd1, 0, 2'd0, 1, 4'hF, 4'hF, 0, 0); cycle();
    // R3 invalid address
    setreq(32'h4000_0000, 2'd2, 1, 2'd0, 1, 4'hF, 4'hF, 0, 0); cycle();
    setreq(32'hA000_0010, 2'd3, 0, 2'd3, 0, 4'h0, 4'h0, 0, 0); cycle();
    // R4 direct-mapped: kernel pass, user fault, lookup ignored
    setreq(32'hE123_4560, 2'd3, 1, 2'd0, 0, 4'h0, 4'h0, 1, 1); cycle();
    setreq(32'hE123_4560, 2'd3, 1, 2'd2, 1, 4'hF, 4'hF, 0, 0); cycle();
    // R5 miss native and pte-load miss (record frozen for the latter, R10)
    setreq(32'hF000_4000, 2'd2, 0, 2'd1, 0, 4'hF, 4'hF, 0, 0); cycle();
    setreq(32'h0000_8000, 2'd3, 1, 2'd1, 0, 4'hF, 4'hF, 0, 0);
    quals(1, 0, 0); cycle(); quals(0, 0, 0);
    // R6 store permission variants
    setreq(32'h0002_0000, 2'd2, 1, 2'd2, 1, 4'hF, 4'hB, 0, 1); cycle();
    setreq(32'h0002_0000, 2'd2, 1, 2'd2, 1, 4'hF, 4'hB, 0, 0); cycle();
    setreq(32'h0002_0008, 2'd2, 1, 2'd1, 1, 4'hF, 4'h2, 0, 1); cycle();
    // R7 load permission variants
    setreq(32'h0003_0000, 2'd2, 0, 2'd3, 1, 4'h7, 4'hF, 1, 0); cycle();
    setreq(32'h0003_0000, 2'd2, 0, 2'd3, 1, 4'h7, 4'hF, 0, 0); cycle();
    setreq(32'h0003_0004, 2'd2, 0, 2'd0, 1, 4'h1, 4'h0, 1, 0); cycle();
    // R10 each qualifier on a fault, then R8/R9 recorded again
    setreq(32'h4000_0000, 2'd0, 1, 2'd0, 1, 4'hF, 4'hF, 0, 0);
    quals(0, 1, 0); cycle(); quals(0, 0, 1); cycle(); quals(0, 0, 0);
    setreq(32'hFFFF_E000, 2'd0, 0, 2'd0, 0, 4'hF, 4'hF, 0, 0); cycle();
    req_valid = 0; cycle(); cycle();
    // randomized mix
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] v = $urandom;
      case ($urandom % 4)
        0: v[31:29] = 3'b000;
        1: begin v[31:28] = 4'b1110; end
        2: v[31:29] = 3'b111;
        default: ;
      endcase
      if ($urandom % 2) v[2:0] = 3'b000;
      req_valid = ($urandom % 5) != 0; req_va = v; req_size = 2'($urandom);
      req_write = 1'($urandom); req_mode = 2'($urandom); tlb_hit = ($urandom % 4) != 0;
      pte_pfn = 15'($urandom); pte_rd_en = 4'($urandom); pte_wr_en = 4'($urandom);
      pte_fonr = ($urandom % 4) == 0; pte_fonw = ($urandom % 4) == 0;
      inst_op = 6'($urandom); inst_ra = 5'($urandom); ptbr = $urandom & 32'hFFFF_0000;
      req_pte_load = ($urandom % 6) == 0; req_nofault = ($urandom % 8) == 0;
      req_misspec = ($urandom % 8) == 0;
      cycle();
    end
    req_valid = 0; cycle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule